// File: doc/BRIEF.md
# Interrupt Requester with Acknowledge Daisy Chain

This block lets a bus slave raise an interrupt on one fixed priority level and take its part in the interrupt-acknowledge daisy chain. A one-cycle pulse on the local request input is captured and held. The block then pulls the active-low interrupt line of its configured level low and waits for an acknowledge cycle to reach it through the incoming chain input.

When a fresh falling edge arrives on the incoming chain during an acknowledge cycle, the block decodes the level from the three address bits. If the level is its own, it intercepts the chain. It waits for the low-order data strobe, puts its status/ID byte on the data output with the enable set, and holds data acknowledge low until the address strobe rises. It then drops the interrupt line. If the level is not its own, it passes the acknowledge on through the outgoing chain. After the address strobe rises, it keeps the outgoing chain low for a minimum release time before letting it go. Whenever the block is not intercepting, the outgoing chain copies the incoming chain, so modules further down the chain are never starved.

All bus inputs are expected to be synchronized to `clk` already.

Top module: `irq_daisy_agent`

## Requirements
- R1: While `rst_n` is low, `chain_out_n` is 1 whatever `chain_in_n` is, every `irq_n` bit is 1, `dtack_n` is 1 and `vec_oe` is 0.
- R2: With no request held, `chain_out_n` follows `chain_in_n` combinationally.
- R3: A `req_i` pulse seen on a clock edge drives `irq_n[IRQ_LEVEL-1]` low from the next edge onward. All other `irq_n` bits stay 1.
- R4: The block arms even when `chain_in_n` is already low. It answers only a later 1-to-0 transition of `chain_in_n`, and it never answers a low level. While armed and not intercepting, `chain_out_n` copies `chain_in_n`.
- R5: On a fresh falling edge of `chain_in_n`, with `as_n` and `iack_n` low and `lvl_addr` different from `IRQ_LEVEL`, `chain_out_n` goes low and stays low. `dtack_n` stays 1 and the interrupt line stays asserted.
- R6: After `as_n` rises on a passed-on acknowledge, `chain_out_n` stays low for HOLD_CYC = ceil(RELEASE_NS / CLK_PERIOD_NS) clock cycles (6 at the defaults). It then copies `chain_in_n` again.
- R7: On a fresh falling edge of `chain_in_n`, with `as_n` and `iack_n` low and `lvl_addr` equal to `IRQ_LEVEL`, `chain_out_n` is held at 1. After the edge on which `ds0_n` is seen low, `dtack_n` is 0, `vec_oe` is 1 and `vec_data` equals STATUS_ID.
- R8: Data acknowledge stays low until `as_n` is seen high on a clock edge. On that edge `dtack_n` and every `irq_n` bit return to 1, `vec_oe` returns to 0, and the held request is cleared.
- R9: A `req_i` pulse that arrives while data acknowledge is low is lost. After the cycle ends the interrupt line stays at 1.
- R10: If `as_n` rises after interception but before `ds0_n` falls, the block keeps its interrupt asserted and waits for a new acknowledge. It does not drive `dtack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Local interrupt request pulse |
| as_n | input | 1 | Synchronized address strobe, active low |
| ds0_n | input | 1 | Synchronized low-order data strobe, active low |
| iack_n | input | 1 | Acknowledge-cycle flag, active low |
| lvl_addr | input | 3 | Level being acknowledged, from address bits 3 to 1 |
| chain_in_n | input | 1 | Incoming acknowledge chain, active low |
| irq_n | output | LINES | Interrupt lines, bit k is level k+1, active low |
| chain_out_n | output | 1 | Outgoing acknowledge chain, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| vec_data | output | 8 | Status/ID byte, zero when not enabled |
| vec_oe | output | 1 | Enable for the status/ID byte |

## Verification
The embedded properties watch rules that hold on every cycle. At most one interrupt line is ever low. Intercepting and passing on never overlap. Data acknowledge falls only after a low data strobe and rises only after the address strobe rises. Leaving the release wait needs at least HOLD_CYC cycles of high address strobe. Interception follows only a true falling edge of the incoming chain. Other behaviours can only be shown by directed scenarios: that arming under an already-low chain does not answer the old acknowledge, that a request pulse during acknowledge is lost, that an aborted cycle re-arms cleanly, and the exact status byte and reset pass-through values.

// File: rtl/irq_daisy_agent.sv
module irq_daisy_agent #(
  parameter int unsigned IRQ_LEVEL     = 3,
  parameter int unsigned LINES         = 7,
  parameter logic [7:0]  STATUS_ID     = 8'hA5,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned RELEASE_NS    = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             as_n,
  input  logic             ds0_n,
  input  logic             iack_n,
  input  logic [2:0]       lvl_addr,
  input  logic             chain_in_n,
  output logic [LINES-1:0] irq_n,
  output logic             chain_out_n,
  output logic             dtack_n,
  output logic [7:0]       vec_data,
  output logic             vec_oe
);

  localparam int unsigned HOLD_CYC = (RELEASE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned CNT_W    = $clog2(HOLD_CYC + 1);
  localparam logic [2:0]  MY_LVL   = 3'(IRQ_LEVEL);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_PASS, S_HOLD, S_ACK, S_DRIVE} st_t;

  st_t             st, st_nx;
  logic            chain_q;
  logic            req_held;
  logic [CNT_W-1:0] cnt;
  logic            irq_on;
  logic            chain_drv;

  wire chain_fell = chain_q && !chain_in_n;
  wire ack_seen   = chain_fell && !as_n && !iack_n;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (req_held) st_nx = S_PEND;
      S_PEND:  if (ack_seen) st_nx = (lvl_addr == MY_LVL) ? S_ACK : S_PASS;
      S_PASS:  if (as_n) st_nx = S_HOLD;
      S_HOLD:  if (cnt == CNT_W'(HOLD_CYC - 1)) st_nx = S_PEND;
      S_ACK:   if (as_n) st_nx = S_PEND;
               else if (!ds0_n) st_nx = S_DRIVE;
      S_DRIVE: if (as_n) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_comb begin
    irq_on    = 1'b0;
    chain_drv = chain_in_n;
    dtack_n   = 1'b1;
    vec_oe    = 1'b0;
    case (st)
      S_PEND:  irq_on = 1'b1;
      S_PASS, S_HOLD: begin
        irq_on    = 1'b1;
        chain_drv = 1'b0;
      end
      S_ACK: begin
        irq_on    = 1'b1;
        chain_drv = 1'b1;
      end
      S_DRIVE: begin
        irq_on    = 1'b1;
        chain_drv = 1'b1;
        dtack_n   = 1'b0;
        vec_oe    = 1'b1;
      end
      default: ;
    endcase
  end

  assign chain_out_n = chain_drv | ~rst_n;
  assign vec_data    = vec_oe ? STATUS_ID : 8'h00;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_n[i] = !(irq_on && (i + 1 == IRQ_LEVEL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      chain_q  <= 1'b1;
      req_held <= 1'b0;
      cnt      <= '0;
    end else begin
      st      <= st_nx;
      chain_q <= chain_in_n;
      cnt     <= (st == S_HOLD) ? cnt + 1'b1 : '0;
      if (st == S_DRIVE && as_n)
        req_held <= 1'b0;
      else if (!req_held || st == S_DRIVE)
        req_held <= req_i;
    end
  end

  logic [CNT_W-1:0] since_as;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_as <= '0;
    else if (!as_n)           since_as <= '0;
    else if (since_as != CNT_W'(HOLD_CYC)) since_as <= since_as + 1'b1;
  end

  assert_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  assert_no_pass_and_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !chain_out_n));

  assert_dtack_after_ds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> !$past(ds0_n));

  assert_dtack_until_as_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> $past(as_n));

  assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && st_nx == S_PEND) |-> since_as >= CNT_W'(HOLD_CYC));

  assert_fresh_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_ACK || st == S_PASS) && $past(st) == S_PEND)
      |-> ($past(chain_in_n, 2) && !$past(chain_in_n)));

endmodule

// File: tb/irq_daisy_agent_test.sv
`timescale 1ns/1ps
module irq_daisy_agent_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic       as_n = 1'b1;
  logic       ds0_n = 1'b1;
  logic       iack_n = 1'b1;
  logic [2:0] lvl_addr = 3'd0;
  logic       chain_in_n = 1'b0;
  logic [6:0] irq_n;
  logic       chain_out_n, dtack_n, vec_oe;
  logic [7:0] vec_data;

  localparam logic [6:0] IRQ_ON  = 7'b1111011;
  localparam logic [6:0] IRQ_OFF = 7'b1111111;

  int n_chk = 0;
  int n_bad = 0;

  irq_daisy_agent uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .as_n(as_n), .ds0_n(ds0_n),
    .iack_n(iack_n), .lvl_addr(lvl_addr), .chain_in_n(chain_in_n),
    .irq_n(irq_n), .chain_out_n(chain_out_n), .dtack_n(dtack_n),
    .vec_data(vec_data), .vec_oe(vec_oe));

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic arm();
    req_i = 1'b1; step(); req_i = 1'b0; step();
    chk("R3 irq line of level 3 low", irq_n, IRQ_ON);
  endtask

  task automatic full_ack();
    as_n = 1'b0; iack_n = 1'b0; lvl_addr = 3'd3; chain_in_n = 1'b0;
    step();
    chk("R7 chain held high on intercept", chain_out_n, 1);
    chk("R7 no dtack before strobe", dtack_n, 1);
    ds0_n = 1'b0; step();
    chk("R7 dtack low", dtack_n, 0);
    chk("R7 vector enable", vec_oe, 1);
    chk("R7 status byte", vec_data, 8'hA5);
    as_n = 1'b1; ds0_n = 1'b1; iack_n = 1'b1; chain_in_n = 1'b1;
    step();
    chk("R8 irq released", irq_n, IRQ_OFF);
    chk("R8 dtack released", dtack_n, 1);
    chk("R8 vector disabled", vec_oe, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 chain out high in reset", chain_out_n, 1);
    chk("R1 irq idle in reset", irq_n, IRQ_OFF);
    chk("R1 dtack idle in reset", dtack_n, 1);
    chk("R1 vector off in reset", vec_oe, 0);
    chain_in_n = 1'b1;
    step(); rst_n = 1'b1; step();
  endtask

  task automatic t_idle_pass();
    chain_in_n = 1'b0; #1;
    chk("R2 follows low", chain_out_n, 0);
    chain_in_n = 1'b1; #1;
    chk("R2 follows high", chain_out_n, 1);
    step();
  endtask

  task automatic t_match();
    arm();
    as_n = 1'b0; iack_n = 1'b0; lvl_addr = 3'd3; chain_in_n = 1'b0;
    step();
    chk("R7 intercept", chain_out_n, 1);
    ds0_n = 1'b0; step();
    chk("R7 dtack", dtack_n, 0);
    chk("R7 byte", vec_data, 8'hA5);
    req_i = 1'b1; step(); req_i = 1'b0; step();
    chk("R8 dtack held while strobe low", dtack_n, 0);
    as_n = 1'b1; ds0_n = 1'b1; iack_n = 1'b1; chain_in_n = 1'b1;
    step();
    chk("R8 irq off after strobe", irq_n, IRQ_OFF);
    chk("R8 dtack off", dtack_n, 1);
    step(); step(); step();
    chk("R9 pulse during ack lost", irq_n, IRQ_OFF);
  endtask

  task automatic t_mismatch();
    arm();
    as_n = 1'b0; iack_n = 1'b0; lvl_addr = 3'd5; chain_in_n = 1'b0;
    step();
    chk("R5 passed on", chain_out_n, 0);
    chk("R5 no dtack", dtack_n, 1);
    chk("R5 irq kept", irq_n, IRQ_ON);
    step();
    as_n = 1'b1; iack_n = 1'b1; chain_in_n = 1'b1;
    step();
    for (int i = 0; i < 6; i++) begin
      chk("R6 chain out held low", chain_out_n, 0);
      step();
    end
    chk("R6 chain out released", chain_out_n, 1);
    full_ack();
  endtask

  task automatic t_armed_low();
    chain_in_n = 1'b0; as_n = 1'b0; iack_n = 1'b0; lvl_addr = 3'd3;
    step();
    arm();
    step(); step(); step();
    chk("R4 no answer to old low", dtack_n, 1);
    chk("R4 pass-through while armed", chain_out_n, 0);
    chk("R4 still requesting", irq_n, IRQ_ON);
    chain_in_n = 1'b1; as_n = 1'b1; iack_n = 1'b1;
    step(); step();
    chk("R4 pass-through high", chain_out_n, 1);
    full_ack();
  endtask

  task automatic t_abort();
    arm();
    as_n = 1'b0; iack_n = 1'b0; lvl_addr = 3'd3; chain_in_n = 1'b0;
    step();
    as_n = 1'b1; iack_n = 1'b1; chain_in_n = 1'b1;
    step();
    chk("R10 irq kept after abort", irq_n, IRQ_ON);
    chk("R10 no dtack after abort", dtack_n, 1);
    step();
    full_ack();
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_idle_pass();
    t_match();
    t_mismatch();
    t_armed_low();
    t_abort();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got hang exp finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule